// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block drives the control strobes of a multiplexed external address/data bus: an address latch strobe, a code-fetch strobe, a data-read strobe, and separate low-byte and high-byte write strobes. A client asks for one bus cycle at a time. Each request names the cycle kind (code fetch, data read or data write), says whether an address latch phase comes first, and supplies the address, the write data and the byte enables. The block then plays out the cycle and pulses `done_o` when the cycle is over.

The shape of every cycle comes from a handful of 2-bit length codes and single-bit width and hold settings. The block derives from them the address latch time, the write setup gap, the strobe width and the write hold time. It runs on a clock at twice the bus clock, so one tick is half a bus clock, and half-clock latch boundaries are exact. An external wait input stretches the active strobe. A data read can only be stretched during all but the last bus clock of its strobe. If a setting leaves no setup time or no read strobe, the block raises an error output and runs the cycle with that phase cut to zero.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `ready_o`=1, `done_o`=0, `cfg_err_o`=0, and no strobe or drive enable is active.
- R2: A code fetch without the latch phase lasts `cfg_code_len`+1 bus clocks, and the code strobe is active for the whole cycle. With the latch phase the fetch lasts `cfg_code_len`+2 bus clocks and the strobe fills what the latch phase leaves.
- R3: A data read without the latch phase lasts `cfg_rd_len`+1 bus clocks, and the read strobe is active for the whole cycle.
- R4: The latch phase is 1 bus clock (latch strobe high for 1 tick) when `cfg_ale_wide`=0, or 2 bus clocks (high for 3 ticks) when it is 1. The last tick of the phase is always a low gap before any other strobe.
- R5: A data read with the latch phase lasts `cfg_rd_ale_len`+2 bus clocks. Its read strobe lasts the total minus the latch phase.
- R6: The write strobe is 1 bus clock wide when `cfg_wr_wide`=0 and 2 when it is 1. `req_be` bit 0 enables `wr_lo_o` and bit 1 enables `wr_hi_o`. Both are active for `req_be`=11.
- R7: A write lasts `cfg_wr_len`+2 bus clocks without the latch phase and `cfg_wr_ale_len`+2 with it. The strobe is followed by a hold of 0 bus clocks (`cfg_wr_hold`=0) or 1 bus clock (`cfg_wr_hold`=1).
- R8: The write setup before the strobe is the total length minus pulse width, minus hold, minus the latch phase when one is present.
- R9: If the write setup or the read strobe width works out to zero or less, `cfg_err_o` is 1 from acceptance until the next acceptance, and that phase is cut to zero. `cfg_err_o` returns to 0 when a valid cycle is accepted.
- R10: While `wait_i` is high, a code or write strobe is held. Each tick of wait adds one tick to the strobe.
- R11: Wait stretches a read strobe only during its first width-minus-one bus clocks. A read strobe of one bus clock cannot be stretched.
- R12: A request is accepted only while `ready_o` is high. Requests made during a cycle are ignored, and the address output stays unchanged. `done_o` is high for exactly one tick, in the first idle tick.
- R13: `ad_oe_o` is high during the latch phase of any cycle and for the whole of a write cycle. It is low during the strobe of a read.
- R14: `req_kind` encoding: 00 is a code fetch, 01 is a data read, and 10 or 11 is a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request a cycle |
| req_kind | input | 2 | Cycle kind (R14) |
| req_ale | input | 1 | Insert an address latch phase |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables for writes |
| cfg_code_len | input | 2 | Code fetch length code |
| cfg_rd_len | input | 2 | Read length code without latch |
| cfg_rd_ale_len | input | 2 | Read length code with latch |
| cfg_wr_len | input | 2 | Write length code without latch |
| cfg_wr_ale_len | input | 2 | Write length code with latch |
| cfg_ale_wide | input | 1 | Wide latch phase |
| cfg_wr_wide | input | 1 | Two-clock write strobe |
| cfg_wr_hold | input | 1 | One-clock write hold |
| wait_i | input | 1 | Stretch active strobe |
| ready_o | output | 1 | Idle, request accepted |
| ale_o | output | 1 | Address latch strobe |
| code_stb_o | output | 1 | Code fetch strobe |
| rd_stb_o | output | 1 | Data read strobe |
| wr_lo_o | output | 1 | Low byte write strobe |
| wr_hi_o | output | 1 | High byte write strobe |
| ad_oe_o | output | 1 | Address/data drive enable |
| addr_o | output | ADDR_W | Latched cycle address |
| wdata_o | output | DATA_W | Latched write data |
| done_o | output | 1 | Cycle finished pulse |
| cfg_err_o | output | 1 | Setting gave no setup or strobe time |

## Verification
The bench sweeps every length code for code fetches and reads with and without the latch phase. This tells apart the +1 and +2 clock offsets and the latch subtraction from the strobe. Writes are run with differing pulse, hold and latch settings and all three byte enable patterns, so the measured setup gap separates each term of the setup formula. Wait is applied to a code fetch, a write, a two-clock read and a one-clock read; the last two show the read guard window. A request made mid-cycle and the error cases with zero setup or zero read strobe close the set.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

   localparam int unsigned TICK_W = 4;

   typedef logic [TICK_W-1:0] tick_t;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ALE   = 3'd1,
      PH_GAP   = 3'd2,
      PH_SETUP = 3'd3,
      PH_STB   = 3'd4,
      PH_HOLD  = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      K_CODE  = 2'd0,
      K_READ  = 2'd1,
      K_WRITE = 2'd2
   } kind_e;

   typedef struct packed {
      logic [1:0] code_len;
      logic [1:0] rd_len;
      logic [1:0] rd_ale_len;
      logic [1:0] wr_len;
      logic [1:0] wr_ale_len;
      logic       ale_wide;
      logic       wr_wide;
      logic       wr_hold;
   } cfg_t;

   // Phase lengths in ticks (one tick = half a bus clock)
   typedef struct packed {
      tick_t ale_hi;
      tick_t gap;
      tick_t setup;
      tick_t stb;
      tick_t hold;
      tick_t guard;   // strobe ticks left below which wait is ignored
   } plan_t;

endpackage

// File: rtl/bus_seq_timing.sv
module bus_seq_timing
   import bus_seq_pkg::*;
(
   input  cfg_t  cfg,
   input  kind_e kind,
   input  logic  use_ale,
   output plan_t plan,
   output logic  err
);

   localparam int TICKS_PER_CLK = 2;

   int clk_len;
   int total;
   int ale_t;
   int pulse_t;
   int hold_t;
   int left_t;

   always_comb begin
      case (kind)
         K_CODE:  clk_len = use_ale ? int'(cfg.code_len) + 2 : int'(cfg.code_len) + 1;
         K_READ:  clk_len = use_ale ? int'(cfg.rd_ale_len) + 2 : int'(cfg.rd_len) + 1;
         default: clk_len = use_ale ? int'(cfg.wr_ale_len) + 2 : int'(cfg.wr_len) + 2;
      endcase
      total   = TICKS_PER_CLK * clk_len;
      ale_t   = use_ale ? (cfg.ale_wide ? 2 * TICKS_PER_CLK : TICKS_PER_CLK) : 0;
      pulse_t = cfg.wr_wide ? 2 * TICKS_PER_CLK : TICKS_PER_CLK;
      hold_t  = cfg.wr_hold ? TICKS_PER_CLK : 0;

      plan        = '0;
      plan.ale_hi = (ale_t != 0) ? TICK_W'(ale_t - 1) : '0;
      plan.gap    = (ale_t != 0) ? tick_t'(1) : '0;

      if (kind == K_WRITE) begin
         left_t     = total - pulse_t - hold_t - ale_t;
         err        = (left_t <= 0);
         plan.setup = (left_t > 0) ? TICK_W'(left_t) : '0;
         plan.stb   = TICK_W'(pulse_t);
         plan.hold  = TICK_W'(hold_t);
      end else begin
         left_t     = total - ale_t;
         err        = (left_t <= 0);
         plan.stb   = (left_t > 0) ? TICK_W'(left_t) : '0;
         plan.guard = (kind == K_READ) ? TICK_W'(TICKS_PER_CLK) : '0;
      end
   end

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
   import bus_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  plan_t  plan,
   input  logic   wait_i,
   output phase_e phase,
   output logic   done
);

   localparam int LAST_PH = int'(PH_HOLD);

   plan_t  plan_q;
   tick_t  cnt;
   phase_e nx_ph;
   phase_e first_ph;
   logic   stall;

   function automatic tick_t len_of(input phase_e p, input plan_t pl);
      tick_t r;
      case (p)
         PH_ALE:   r = pl.ale_hi;
         PH_GAP:   r = pl.gap;
         PH_SETUP: r = pl.setup;
         PH_STB:   r = pl.stb;
         PH_HOLD:  r = pl.hold;
         default:  r = '0;
      endcase
      return r;
   endfunction

   // first later phase with a nonzero length, idle if none is left
   function automatic phase_e after(input phase_e p, input plan_t pl);
      phase_e n;
      n = PH_IDLE;
      for (int i = LAST_PH; i >= 1; i--) begin
         if (i > int'(p) && len_of(phase_e'(3'(i)), pl) != '0)
            n = phase_e'(3'(i));
      end
      return n;
   endfunction

   always_comb begin
      nx_ph    = after(phase, plan_q);
      first_ph = after(PH_IDLE, plan);
      stall    = (phase == PH_STB) && wait_i && (cnt > plan_q.guard);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         plan_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               plan_q <= plan;
               phase  <= first_ph;
               cnt    <= len_of(first_ph, plan);
            end
         end else if (stall) begin
            cnt <= cnt;
         end else if (cnt == tick_t'(1) || cnt == '0) begin
            phase <= nx_ph;
            cnt   <= len_of(nx_ph, plan_q);
            done  <= (nx_ph == PH_IDLE);
         end else begin
            cnt <= cnt - tick_t'(1);
         end
      end
   end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bus_seq_pkg::*;
#(
   parameter int unsigned ADDR_W         = 20,
   parameter int unsigned DATA_W         = 16,
   parameter bit          STROBE_ACT_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_ale,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   input  logic [1:0]        cfg_code_len,
   input  logic [1:0]        cfg_rd_len,
   input  logic [1:0]        cfg_rd_ale_len,
   input  logic [1:0]        cfg_wr_len,
   input  logic [1:0]        cfg_wr_ale_len,
   input  logic              cfg_ale_wide,
   input  logic              cfg_wr_wide,
   input  logic              cfg_wr_hold,
   input  logic              wait_i,
   output logic              ready_o,
   output logic              ale_o,
   output logic              code_stb_o,
   output logic              rd_stb_o,
   output logic              wr_lo_o,
   output logic              wr_hi_o,
   output logic              ad_oe_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              done_o,
   output logic              cfg_err_o
);

   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_data_w
      $error("bus_cycle_seq: DATA_W must be 8 or 16");
   end
   if (ADDR_W < DATA_W) begin : g_bad_addr_w
      $error("bus_cycle_seq: ADDR_W must cover the multiplexed data width");
   end

   cfg_t   cfg;
   kind_e  req_k;
   kind_e  kind_q;
   plan_t  plan;
   logic   plan_err;
   phase_e phase;
   logic   start;
   logic   err_q;
   logic [1:0] be_q;

   logic s_ready, s_ale, s_code, s_rd, s_wlo, s_whi, s_done, s_oe, s_wr;

   always_comb begin
      cfg.code_len   = cfg_code_len;
      cfg.rd_len     = cfg_rd_len;
      cfg.rd_ale_len = cfg_rd_ale_len;
      cfg.wr_len     = cfg_wr_len;
      cfg.wr_ale_len = cfg_wr_ale_len;
      cfg.ale_wide   = cfg_ale_wide;
      cfg.wr_wide    = cfg_wr_wide;
      cfg.wr_hold    = cfg_wr_hold;
      req_k = req_kind[1] ? K_WRITE : (req_kind[0] ? K_READ : K_CODE);
   end

   bus_seq_timing i_timing (
      .cfg     (cfg),
      .kind    (req_k),
      .use_ale (req_ale),
      .plan    (plan),
      .err     (plan_err)
   );

   assign s_ready = (phase == PH_IDLE);
   assign start   = req_valid && s_ready;

   bus_seq_fsm i_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .plan   (plan),
      .wait_i (wait_i),
      .phase  (phase),
      .done   (s_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= K_CODE;
         err_q   <= 1'b0;
         be_q    <= '0;
         addr_o  <= '0;
         wdata_o <= '0;
      end else if (start) begin
         kind_q  <= req_k;
         err_q   <= plan_err;
         be_q    <= req_be;
         addr_o  <= req_addr;
         wdata_o <= req_wdata;
      end
   end

   always_comb begin
      s_ale  = (phase == PH_ALE);
      s_code = (phase == PH_STB) && (kind_q == K_CODE);
      s_rd   = (phase == PH_STB) && (kind_q == K_READ);
      s_wr   = (phase == PH_STB) && (kind_q == K_WRITE);
      s_oe   = (phase == PH_ALE) || (phase == PH_GAP) ||
               ((kind_q == K_WRITE) && !s_ready);
   end

   if (LANES == 2) begin : g_wide_bus
      assign s_wlo = s_wr && be_q[0];
      assign s_whi = s_wr && be_q[1];
   end else begin : g_narrow_bus
      assign s_wlo = s_wr && (|be_q);
      assign s_whi = 1'b0;
   end

   if (STROBE_ACT_LOW) begin : g_act_low
      assign ale_o      = ~s_ale;
      assign code_stb_o = ~s_code;
      assign rd_stb_o   = ~s_rd;
      assign wr_lo_o    = ~s_wlo;
      assign wr_hi_o    = ~s_whi;
   end else begin : g_act_high
      assign ale_o      = s_ale;
      assign code_stb_o = s_code;
      assign rd_stb_o   = s_rd;
      assign wr_lo_o    = s_wlo;
      assign wr_hi_o    = s_whi;
   end

   assign ready_o   = s_ready;
   assign ad_oe_o   = s_oe;
   assign done_o    = s_done;
   assign cfg_err_o = err_q;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
   parameter int unsigned ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              ale,
   input logic              code_stb,
   input logic              rd_stb,
   input logic              wr_lo,
   input logic              wr_hi,
   input logic              done,
   input logic              wait_i,
   input logic [ADDR_W-1:0] addr
);

   // R1: nothing is driven while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !(ale || code_stb || rd_stb || wr_lo || wr_hi));

   // R6: at most one kind of strobe at a time
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ale, code_stb, rd_stb, wr_lo || wr_hi}));

   // R4: the tick after the latch strobe is a quiet gap
   p_ale_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> !(code_stb || rd_stb || wr_lo || wr_hi));

   // R12: done lasts one tick and coincides with idle
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   // R12: address does not move while a cycle runs
   p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(addr));

   // R10: wait holds a code or write strobe
   p_code_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (code_stb && wait_i) |=> code_stb);
   p_wr_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_lo || wr_hi) && wait_i) |=> (wr_lo || wr_hi));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready    (s_ready),
   .ale      (s_ale),
   .code_stb (s_code),
   .rd_stb   (s_rd),
   .wr_lo    (s_wlo),
   .wr_hi    (s_whi),
   .done     (s_done),
   .wait_i   (wait_i),
   .addr     (addr_o)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

   localparam int ADDR_W = 20;
   localparam int DATA_W = 16;
   localparam int WATCH  = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic req_ale = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [1:0] req_be = 2'b00;
   logic [1:0] cfg_code_len = 2'd0, cfg_rd_len = 2'd0, cfg_rd_ale_len = 2'd0;
   logic [1:0] cfg_wr_len = 2'd0, cfg_wr_ale_len = 2'd0;
   logic cfg_ale_wide = 1'b0, cfg_wr_wide = 1'b0, cfg_wr_hold = 1'b1;
   logic wait_i = 1'b0;
   logic ready_o, ale_o, code_stb_o, rd_stb_o, wr_lo_o, wr_hi_o, ad_oe_o, done_o, cfg_err_o;
   logic [ADDR_W-1:0] addr_o;
   logic [DATA_W-1:0] wdata_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int m_total, m_ale, m_stb, m_first, m_lo, m_hi, m_oe, m_err;

   always #2 clk = ~clk;

   bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_cycle_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_ale(req_ale), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .cfg_code_len(cfg_code_len), .cfg_rd_len(cfg_rd_len), .cfg_rd_ale_len(cfg_rd_ale_len),
      .cfg_wr_len(cfg_wr_len), .cfg_wr_ale_len(cfg_wr_ale_len), .cfg_ale_wide(cfg_ale_wide),
      .cfg_wr_wide(cfg_wr_wide), .cfg_wr_hold(cfg_wr_hold), .wait_i(wait_i),
      .ready_o(ready_o), .ale_o(ale_o), .code_stb_o(code_stb_o), .rd_stb_o(rd_stb_o),
      .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o), .ad_oe_o(ad_oe_o), .addr_o(addr_o),
      .wdata_o(wdata_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // issue one cycle and measure it tick by tick
   task automatic run_cycle(input logic [1:0] kind, input logic ale, input logic [1:0] be,
                            input int waits);
      int idx = 0;
      int wl  = waits;
      logic stb;
      @(negedge clk);
      req_kind = kind; req_ale = ale; req_be = be;
      req_addr = req_addr + 20'h11; req_wdata = req_wdata + 16'h0101;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      m_ale = 0; m_stb = 0; m_first = -1; m_lo = 0; m_hi = 0; m_oe = 0;
      while (!done_o && idx < 64) begin
         stb = code_stb_o | rd_stb_o | wr_lo_o | wr_hi_o;
         if (stb) begin
            m_stb++;
            if (m_first < 0) m_first = idx;
         end
         if (ale_o) m_ale++;
         if (wr_lo_o) m_lo++;
         if (wr_hi_o) m_hi++;
         if (ad_oe_o) m_oe++;
         if (stb && wl > 0) begin wait_i = 1'b1; wl--; end
         else wait_i = 1'b0;
         idx++;
         @(negedge clk);
      end
      wait_i = 1'b0;
      m_total = idx;
      m_err = int'(cfg_err_o);
      if (idx >= 64) chk("cycle never finished", 0, 1);
   endtask

   task automatic t_reset;
      chk("R1 ready in reset", int'(ready_o), 1);
      chk("R1 strobes in reset", int'(ale_o|code_stb_o|rd_stb_o|wr_lo_o|wr_hi_o|ad_oe_o), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done idle", int'(done_o), 0);
      chk("R1 err idle", int'(cfg_err_o), 0);
      chk("R1 ready idle", int'(ready_o), 1);
   endtask

   task automatic t_code;
      for (int n = 0; n < 4; n++) begin
         cfg_code_len = 2'(n);
         run_cycle(2'b00, 1'b0, 2'b00, 0);
         chk("R2 code total", m_total, 2 * (n + 1));
         chk("R2 code strobe", m_stb, 2 * (n + 1));
         chk("R14 code no write", m_lo + m_hi, 0);
      end
      cfg_code_len = 2'd2; cfg_ale_wide = 1'b1;
      run_cycle(2'b00, 1'b1, 2'b00, 0);
      chk("R2 code ale total", m_total, 8);
      chk("R4 wide ale high", m_ale, 3);
      chk("R2 code ale strobe", m_stb, 4);
      chk("R4 strobe after gap", m_first, 4);
      cfg_ale_wide = 1'b0;
   endtask

   task automatic t_read;
      for (int n = 0; n < 4; n++) begin
         cfg_rd_len = 2'(n);
         run_cycle(2'b01, 1'b0, 2'b00, 0);
         chk("R3 read total", m_total, 2 * (n + 1));
         chk("R3 read strobe", m_stb, 2 * (n + 1));
         chk("R13 read no drive", m_oe, 0);
      end
      for (int n = 0; n < 4; n++) begin
         cfg_rd_ale_len = 2'(n);
         run_cycle(2'b01, 1'b1, 2'b00, 0);
         chk("R5 read ale total", m_total, 2 * (n + 2));
         chk("R4 narrow ale high", m_ale, 1);
         chk("R5 read ale strobe", m_stb, 2 * (n + 2) - 2);
         chk("R4 narrow strobe start", m_first, 2);
         chk("R13 drive in latch phase", m_oe, 2);
         chk("R9 no error", m_err, 0);
      end
      // zero read strobe: 2-clock cycle with 2-clock latch phase
      cfg_rd_ale_len = 2'd0; cfg_ale_wide = 1'b1;
      run_cycle(2'b01, 1'b1, 2'b00, 0);
      chk("R9 read err flag", m_err, 1);
      chk("R9 read clamped strobe", m_stb, 0);
      chk("R9 read clamped total", m_total, 4);
      cfg_ale_wide = 1'b0;
   endtask

   task automatic t_write;
      // with latch: T=10, P=4, H=2, A=2 -> setup 2
      cfg_wr_ale_len = 2'd3; cfg_wr_wide = 1'b1; cfg_wr_hold = 1'b1;
      run_cycle(2'b10, 1'b1, 2'b11, 0);
      chk("R7 write ale total", m_total, 10);
      chk("R8 write ale setup", m_first, 4);
      chk("R6 wide pulse lo", m_lo, 4);
      chk("R6 wide pulse hi", m_hi, 4);
      chk("R7 hold after strobe", m_total - m_first - m_stb, 2);
      chk("R13 write drive", m_oe, 10);
      chk("R9 write ok", m_err, 0);
      // no latch: T=10, P=2, H=2 -> setup 6
      cfg_wr_len = 2'd3; cfg_wr_wide = 1'b0;
      run_cycle(2'b11, 1'b0, 2'b01, 0);
      chk("R8 write setup", m_first, 6);
      chk("R6 low byte only", m_lo, 2);
      chk("R6 no high byte", m_hi, 0);
      // no hold: T=6, P=2, H=0 -> setup 4
      cfg_wr_len = 2'd1; cfg_wr_hold = 1'b0;
      run_cycle(2'b10, 1'b0, 2'b10, 0);
      chk("R7 zero hold total", m_total, 6);
      chk("R8 zero hold setup", m_first, 4);
      chk("R6 high byte only", m_hi, 2);
      chk("R6 no low byte", m_lo, 0);
      // zero setup: T=4, P=2, H=2
      cfg_wr_len = 2'd0; cfg_wr_hold = 1'b1;
      run_cycle(2'b10, 1'b0, 2'b11, 0);
      chk("R9 write err flag", m_err, 1);
      chk("R9 clamped setup", m_first, 0);
      chk("R9 clamped total", m_total, 4);
      cfg_wr_len = 2'd3;
      run_cycle(2'b10, 1'b0, 2'b11, 0);
      chk("R9 err cleared", m_err, 0);
   endtask

   task automatic t_wait;
      cfg_code_len = 2'd1;
      run_cycle(2'b00, 1'b0, 2'b00, 3);
      chk("R10 code stretched", m_stb, 7);
      cfg_wr_len = 2'd3; cfg_wr_wide = 1'b0; cfg_wr_hold = 1'b1;
      run_cycle(2'b10, 1'b0, 2'b11, 2);
      chk("R10 write stretched", m_stb, 4);
      chk("R10 write total", m_total, 12);
      cfg_rd_len = 2'd0;
      run_cycle(2'b01, 1'b0, 2'b00, 3);
      chk("R11 one-clock read not stretched", m_total, 2);
      cfg_rd_len = 2'd1;
      run_cycle(2'b01, 1'b0, 2'b00, 3);
      chk("R11 two-clock read stretched", m_total, 7);
   endtask

   task automatic t_busy;
      int idx = 0;
      logic [ADDR_W-1:0] first_addr;
      cfg_code_len = 2'd3;
      @(negedge clk);
      req_kind = 2'b00; req_ale = 1'b0; req_addr = 20'h3_1234; first_addr = 20'h3_1234;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 busy not ready", int'(ready_o), 0);
      idx++; @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b10; req_addr = 20'h0_0abc;
      idx++; @(negedge clk);
      req_valid = 1'b0;
      chk("R12 addr kept", int'(addr_o == first_addr), 1);
      chk("R12 kind kept", int'(code_stb_o), 1);
      while (!done_o && idx < 64) begin idx++; @(negedge clk); end
      chk("R12 total unchanged", idx, 8);
      chk("R12 ready at done", int'(ready_o), 1);
      @(negedge clk);
      chk("R12 done one tick", int'(done_o), 0);
      chk("R12 stays idle", int'(ready_o & ~code_stb_o & ~wr_lo_o), 1);
   endtask

   initial begin
      t_reset();
      t_code();
      t_read();
      t_write();
      t_wait();
      t_busy();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCH) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule